// File: doc/BRIEF.md
# Delay-Slot Branch Resolver

This unit settles control-flow instructions for a 64-bit in-order pipeline whose branches and jumps each carry exactly one delay slot. Each cycle in which `in_valid` is high, it accepts one instruction word with its address and the values of its two source registers. It decides whether the instruction is a branch or jump, evaluates the condition, and forms the destination.

It then reports three kinds of result:
- a return-address write for the linking forms;
- a one-cycle kill pulse when a "likely" branch falls through, so that its delay slot is discarded;
- a redirect, issued once the delay-slot instruction has been accepted, which fetch applies from then on.

A branch or jump that turns up inside a delay slot is not executed. Instead it raises a fault pulse.

The unit holds only a few bits of sequencing state: whether the next accepted instruction is a delay slot, whether it must be skipped, and the pending destination. Fetch, the register file and exception entry sit around it and are not part of it.

Top module: `brx_unit`

## Requirements
- R1: After a synchronous active-low reset, all outputs are low and no delay slot or skip is pending, so the first instruction after reset is treated as an ordinary instruction.
- R2: A relative branch forms its destination as (address + 4) plus the 16-bit field `instr[15:0]`, sign-extended and multiplied by four. `redir_valid` and `redir_target` show it in the cycle after the delay-slot instruction is accepted, for one cycle.
- R3: The two region jumps (opcode `instr[31:26]` = 0x02 plain, 0x03 linking) always redirect. Their destination keeps bits 63:28 of (address + 4), takes `instr[25:0]` shifted left by two for bits 27:2, and has zeros in bits 1:0.
- R4: The condition encodings and tests are as follows. All register comparisons use full 64-bit values, and sign tests are two's complement.
  - Opcode 0x04 tests rs == rt and opcode 0x05 tests rs != rt.
  - Opcode 0x06 tests rs <= 0 and opcode 0x07 tests rs > 0.
  - Opcodes 0x14 to 0x17 are the likely versions of 0x04 to 0x07.
  - Opcode 0x01 tests rs >= 0, with the form selected by `instr[20:16]`: 0x01 plain, 0x03 likely, 0x11 linking, 0x13 linking likely.
- R5: An ordinary (non-likely) conditional branch that is not taken still occupies a delay slot, and redirects to address + 8 after it.
- R6: A likely branch that is not taken raises `slot_kill` for one cycle after it is accepted. The next accepted instruction is then ignored entirely (no outputs, even if it is a branch), and no redirect follows. A likely branch that is taken behaves like an ordinary taken branch.
- R7: The linking forms (opcode 0x03, and opcode 0x01 with `instr[20:16]` = 0x11 or 0x13) pulse `link_we` in the cycle after acceptance, with `link_data` = address + 8, whether or not the branch is taken.
- R8: A branch or jump accepted as a delay-slot instruction pulses `branch_fault` in the cycle after it. It produces no link write, kill or redirect of its own. The redirect of the branch that owns the slot is still issued in that same cycle.
- R9: Cycles with `in_valid` low change no state, so a delay-slot instruction may arrive any number of cycles after its branch.
- R10: Instructions outside the encodings in R3 and R4, including opcode 0x01 with any other `instr[20:16]` value, produce no output when they are not in a delay slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | 64 | Address of the presented instruction |
| in_instr | input | 32 | Instruction word |
| in_rs | input | 64 | Value of the first source register |
| in_rt | input | 64 | Value of the second source register |
| redir_valid | output | 1 | Fetch must continue at `redir_target` |
| redir_target | output | 64 | Destination of the resolved branch or jump |
| link_we | output | 1 | Write the return address into register 31 |
| link_data | output | 64 | Return address (branch address + 8) |
| slot_kill | output | 1 | Discard the delay slot of a likely branch that fell through |
| branch_fault | output | 1 | A branch or jump was found in a delay slot |

## Verification
The hardest situations to reach from the ports are those where the sequencing state meets an unusual next instruction. Three stand out:
- a branch placed in the slot of a likely branch that fell through, which must vanish without a fault;
- a linking jump placed in a live delay slot, which must fault without writing a link;
- a delay slot separated from its branch by idle cycles or by a reset.

The stimulus builds these as explicit back-to-back instruction pairs with chosen register values, so that each condition falls on both sides of its boundary (zero, the most negative value, equal and unequal operands). A behavioural model in the bench tracks the slot and skip state and predicts every output each cycle.

// File: rtl/brx_pkg.sv
// Shared encodings and decode record for the delay-slot branch resolver.
// Assumes the classic 32-bit word: major opcode in bits 31:26, second
// register / sub-opcode in bits 20:16.
package brx_pkg;

    localparam logic [5:0] OPC_REGIMM = 6'h01;
    localparam logic [5:0] OPC_J      = 6'h02;
    localparam logic [5:0] OPC_JAL    = 6'h03;
    localparam logic [5:0] OPC_EQ     = 6'h04;
    localparam logic [5:0] OPC_NE     = 6'h05;
    localparam logic [5:0] OPC_LEZ    = 6'h06;
    localparam logic [5:0] OPC_GTZ    = 6'h07;
    localparam logic [5:0] OPC_EQ_L   = 6'h14;
    localparam logic [5:0] OPC_NE_L   = 6'h15;
    localparam logic [5:0] OPC_LEZ_L  = 6'h16;
    localparam logic [5:0] OPC_GTZ_L  = 6'h17;

    localparam logic [4:0] SUB_GEZ     = 5'h01;
    localparam logic [4:0] SUB_GEZ_L   = 5'h03;
    localparam logic [4:0] SUB_GEZ_K   = 5'h11;
    localparam logic [4:0] SUB_GEZ_K_L = 5'h13;

    typedef enum logic [2:0] {
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_GEZ,
        CND_ALWAYS
    } cond_e;

    typedef struct packed {
        logic  is_br;    // branch or jump of any kind
        logic  likely;   // fall-through kills the delay slot
        logic  link;     // writes the return address
        logic  region;   // destination from the 26-bit index
        cond_e cond;     // condition to evaluate
    } br_info_t;

endpackage

// File: rtl/brx_decode.sv
// Classifies an instruction word as a branch or jump and extracts its
// condition, likely, link and region attributes. Purely combinational;
// assumes only the opcode and sub-opcode fields matter for the decision.
module brx_decode
    import brx_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] subop,
    output br_info_t   info
);

    // Map opcode/sub-opcode to a branch description.
    always_comb begin
        info = '{is_br: 1'b0, likely: 1'b0, link: 1'b0, region: 1'b0, cond: CND_ALWAYS};
        unique case (opcode)
            OPC_J:     begin info.is_br = 1'b1; info.region = 1'b1; end
            OPC_JAL:   begin info.is_br = 1'b1; info.region = 1'b1; info.link = 1'b1; end
            OPC_EQ:    begin info.is_br = 1'b1; info.cond = CND_EQ;  end
            OPC_NE:    begin info.is_br = 1'b1; info.cond = CND_NE;  end
            OPC_LEZ:   begin info.is_br = 1'b1; info.cond = CND_LEZ; end
            OPC_GTZ:   begin info.is_br = 1'b1; info.cond = CND_GTZ; end
            OPC_EQ_L:  begin info.is_br = 1'b1; info.cond = CND_EQ;  info.likely = 1'b1; end
            OPC_NE_L:  begin info.is_br = 1'b1; info.cond = CND_NE;  info.likely = 1'b1; end
            OPC_LEZ_L: begin info.is_br = 1'b1; info.cond = CND_LEZ; info.likely = 1'b1; end
            OPC_GTZ_L: begin info.is_br = 1'b1; info.cond = CND_GTZ; info.likely = 1'b1; end
            OPC_REGIMM: begin
                unique case (subop)
                    SUB_GEZ:     begin info.is_br = 1'b1; info.cond = CND_GEZ; end
                    SUB_GEZ_L:   begin info.is_br = 1'b1; info.cond = CND_GEZ; info.likely = 1'b1; end
                    SUB_GEZ_K:   begin info.is_br = 1'b1; info.cond = CND_GEZ; info.link = 1'b1; end
                    SUB_GEZ_K_L: begin
                        info.is_br  = 1'b1;
                        info.cond   = CND_GEZ;
                        info.link   = 1'b1;
                        info.likely = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/brx_cond.sv
// Evaluates a branch condition on full-width register values.
// Assumes two's-complement signed interpretation for the sign tests.
module brx_cond
    import brx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            taken
);

    logic neg;
    logic zero;

    // Sign and zero flags of the first operand.
    always_comb begin
        neg  = a[XLEN-1];
        zero = (a == '0);
    end

    // Select the outcome for the requested test.
    always_comb begin
        unique case (cond)
            CND_EQ:  taken = (a == b);
            CND_NE:  taken = (a != b);
            CND_LEZ: taken = neg | zero;
            CND_GTZ: taken = ~neg & ~zero;
            CND_GEZ: taken = ~neg;
            default: taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/brx_target.sv
// Forms the relative and region destinations and the sequential address
// two words ahead (used as fall-through and return address).
// Assumes 4-byte instruction words.
module brx_target #(
    parameter int XLEN  = 64,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IDX_W-1:0] field,
    input  logic             region,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  seq8
);

    localparam int REG_LSB = IDX_W + 2;

    logic [XLEN-1:0] seq4;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_tgt;

    // Sequential addresses after the branch and after its slot.
    always_comb begin
        seq4 = pc + XLEN'(4);
        seq8 = pc + XLEN'(8);
    end

    // Word offset sign-extended and scaled to bytes; region splice.
    always_comb begin
        rel_off = {{(XLEN-OFF_W-2){field[OFF_W-1]}}, field[OFF_W-1:0], 2'b00};
        rel_tgt = seq4 + rel_off;
        reg_tgt = {seq4[XLEN-1:REG_LSB], field, 2'b00};
    end

    // Pick the form the instruction asks for.
    always_comb begin
        target = region ? reg_tgt : rel_tgt;
    end

endmodule

// File: rtl/brx_unit.sv
// Delay-slot branch resolver top. Accepts one instruction per valid
// cycle, resolves branches and jumps, and sequences the single delay
// slot: redirect after the slot, kill pulse for a failed likely branch,
// fault for a branch found in a slot. All outputs are registered pulses
// except the data buses, which hold their last value.
module brx_unit
    import brx_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IW    = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_pc,
    input  logic [IW-1:0]   in_instr,
    input  logic [XLEN-1:0] in_rs,
    input  logic [XLEN-1:0] in_rt,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_target,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            slot_kill,
    output logic            branch_fault
);

    br_info_t        info;
    logic            taken;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq8;

    logic            in_slot_q;
    logic            skip_q;
    logic [XLEN-1:0] pend_q;

    brx_decode u_dec (
        .opcode (in_instr[IW-1:IW-6]),
        .subop  (in_instr[20:16]),
        .info   (info)
    );

    brx_cond #(.XLEN(XLEN)) u_cond (
        .cond  (info.cond),
        .a     (in_rs),
        .b     (in_rt),
        .taken (taken)
    );

    brx_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .pc     (in_pc),
        .field  (in_instr[IDX_W-1:0]),
        .region (info.region),
        .target (tgt),
        .seq8   (seq8)
    );

    // Slot sequencing state and pending destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_slot_q <= 1'b0;
            skip_q    <= 1'b0;
            pend_q    <= '0;
        end else if (in_valid) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else if (in_slot_q) begin
                in_slot_q <= 1'b0;
            end else if (info.is_br) begin
                if (info.likely && !taken) begin
                    skip_q <= 1'b1;
                end else begin
                    in_slot_q <= 1'b1;
                    pend_q    <= taken ? tgt : seq8;
                end
            end
        end
    end

    // One-cycle result pulses and their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid  <= 1'b0;
            redir_target <= '0;
            link_we      <= 1'b0;
            link_data    <= '0;
            slot_kill    <= 1'b0;
            branch_fault <= 1'b0;
        end else begin
            redir_valid  <= 1'b0;
            link_we      <= 1'b0;
            slot_kill    <= 1'b0;
            branch_fault <= 1'b0;
            if (in_valid && !skip_q) begin
                if (in_slot_q) begin
                    redir_valid  <= 1'b1;
                    redir_target <= pend_q;
                    branch_fault <= info.is_br;
                end else if (info.is_br) begin
                    link_we   <= info.link;
                    slot_kill <= info.likely & ~taken;
                    if (info.link) begin
                        link_data <= seq8;
                    end
                end
            end
        end
    end

endmodule

// Temporal checks on the resolver's ports.
module brx_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_pc,
    input logic            redir_valid,
    input logic            link_we,
    input logic [XLEN-1:0] link_data,
    input logic            slot_kill,
    input logic            branch_fault
);

    // R6/R8: a slot is either killed or closed with a redirect, never both.
    p_kill_xor_redir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redir_valid, slot_kill}));

    // R8: a fault accompanies the owner's redirect and never a link.
    p_fault_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_fault |-> (redir_valid && !link_we));

    // R7: the return address is the linking instruction's address plus 8.
    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == $past(in_pc) + XLEN'(8)));

    // R6: the skipped slot produces nothing.
    p_kill_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_kill |=> (!redir_valid && !branch_fault && !link_we));

    // R5: a redirect needs a branch and a slot, so never two in a row.
    p_redir_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R9: pulses only follow an accepted instruction.
    p_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid || link_we || slot_kill || branch_fault) |-> $past(in_valid));

endmodule

bind brx_unit brx_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_pc        (in_pc),
    .redir_valid  (redir_valid),
    .link_we      (link_we),
    .link_data    (link_data),
    .slot_kill    (slot_kill),
    .branch_fault (branch_fault)
);

// File: tb/brx_unit_bench.sv
// Bench for brx_unit: behavioural model predicts every output each cycle.
module brx_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_pc = '0;
    logic [31:0] in_instr = '0;
    logic [63:0] in_rs = '0;
    logic [63:0] in_rt = '0;
    logic        redir_valid;
    logic [63:0] redir_target;
    logic        link_we;
    logic [63:0] link_data;
    logic        slot_kill;
    logic        branch_fault;

    always #2 clk = ~clk;

    brx_unit u_brx_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_pc        (in_pc),
        .in_instr     (in_instr),
        .in_rs        (in_rs),
        .in_rt        (in_rt),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .link_we      (link_we),
        .link_data    (link_data),
        .slot_kill    (slot_kill),
        .branch_fault (branch_fault)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state and expectations
    bit          m_slot = 1'b0;
    bit          m_skip = 1'b0;
    logic [63:0] m_pend = '0;
    bit          e_rv = 1'b0, e_lw = 1'b0, e_kill = 1'b0, e_flt = 1'b0;
    logic [63:0] e_rt = '0, e_ld = '0;
    string       e_tag = "R1";

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(e_tag, "redir_valid", 64'(redir_valid), 64'(e_rv));
        check(e_tag, "link_we", 64'(link_we), 64'(e_lw));
        check(e_tag, "slot_kill", 64'(slot_kill), 64'(e_kill));
        check(e_tag, "branch_fault", 64'(branch_fault), 64'(e_flt));
        if (e_rv) check(e_tag, "redir_target", redir_target, e_rt);
        if (e_lw) check(e_tag, "link_data", link_data, e_ld);
    endtask

    // Behavioural prediction of the next cycle's outputs.
    task automatic model(bit rn, bit v, logic [63:0] pc, logic [31:0] ins,
                         logic [63:0] a, logic [63:0] b);
        bit br = 0, cond = 0, lik = 0, lnk = 0, jmp = 0;
        longint sa = longint'(a);
        longint off = longint'($signed(ins[15:0]));
        logic [63:0] dest;
        e_rv = 0; e_lw = 0; e_kill = 0; e_flt = 0;
        if (!rn) begin
            m_slot = 0; m_skip = 0;
            return;
        end
        if (!v) return;
        case (ins[31:26])
            6'h02: begin br = 1; jmp = 1; end
            6'h03: begin br = 1; jmp = 1; lnk = 1; end
            6'h04, 6'h14: begin br = 1; cond = (a == b); end
            6'h05, 6'h15: begin br = 1; cond = (a != b); end
            6'h06, 6'h16: begin br = 1; cond = (sa <= 0); end
            6'h07, 6'h17: begin br = 1; cond = (sa > 0); end
            6'h01: begin
                case (ins[20:16])
                    5'h01: br = 1;
                    5'h03: begin br = 1; lik = 1; end
                    5'h11: begin br = 1; lnk = 1; end
                    5'h13: begin br = 1; lnk = 1; lik = 1; end
                    default: br = 0;
                endcase
                cond = (sa >= 0);
            end
            default: br = 0;
        endcase
        if (ins[31:26] inside {6'h14, 6'h15, 6'h16, 6'h17}) lik = 1;
        if (jmp) cond = 1;
        if (m_skip) begin
            m_skip = 0;
        end else if (m_slot) begin
            m_slot = 0;
            e_rv = 1; e_rt = m_pend;
            e_flt = br;
        end else if (br) begin
            if (lnk) begin e_lw = 1; e_ld = pc + 64'd8; end
            if (jmp) dest = ((pc + 64'd4) & ~64'h0FFF_FFFF) | (64'(ins[25:0]) << 2);
            else     dest = pc + 64'd4 + 64'(off * 4);
            if (lik && !cond) begin
                e_kill = 1; m_skip = 1;
            end else begin
                m_slot = 1;
                m_pend = cond ? dest : pc + 64'd8;
            end
        end
    endtask

    task automatic step(bit rn, bit v, logic [63:0] pc, logic [31:0] ins,
                        logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        compare();
        rst_n = rn; in_valid = v; in_pc = pc; in_instr = ins; in_rs = a; in_rt = b;
        model(rn, v, pc, ins, a, b);
        e_tag = tag;
    endtask

    task automatic ins(logic [63:0] pc, logic [31:0] w, logic [63:0] a, logic [63:0] b, string tag);
        step(1'b1, 1'b1, pc, w, a, b, tag);
    endtask

    task automatic idle(string tag);
        step(1'b1, 1'b0, 64'h0, 32'h0, 64'h0, 64'h0, tag);
    endtask

    task automatic rst(string tag);
        step(1'b0, 1'b0, 64'h0, 32'h0, 64'h0, 64'h0, tag);
    endtask

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] sub, logic [15:0] off);
        return {op, 5'd3, sub, off};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] idx);
        return {op, idx};
    endfunction

    localparam logic [31:0] NOP_ADD = 32'h2463_0001;
    localparam logic [63:0] NEG     = 64'h8000_0000_0000_0000;
    localparam logic [63:0] M1      = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        // R1: reset state
        rst("R1"); rst("R1"); rst("R1");
        // R10: ordinary instruction and unsupported sub-opcode
        ins(64'h1000, NOP_ADD, 5, 5, "R10");
        ins(64'h1004, enc_i(6'h01, 5'h00, 16'h0010), M1, 0, "R10");
        idle("R10");
        // R2: equal taken, positive offset -> 0x1044
        ins(64'h1000, enc_i(6'h04, 5'd4, 16'h0010), 5, 5, "R2");
        ins(64'h1004, NOP_ADD, 0, 0, "R2");
        idle("R2");
        // R5: equal not taken -> pc+8
        ins(64'h1100, enc_i(6'h04, 5'd4, 16'h0010), 5, 6, "R5");
        ins(64'h1104, NOP_ADD, 0, 0, "R5");
        idle("R5");
        // R2: not-equal taken, negative offset -> 0x1FC4
        ins(64'h2000, enc_i(6'h05, 5'd4, 16'hFFF0), 1, 2, "R2");
        ins(64'h2004, NOP_ADD, 0, 0, "R2");
        // R4: <=0 with zero taken; >0 with zero and with most negative not taken
        ins(64'h3000, enc_i(6'h06, 5'd0, 16'h0004), 0, 0, "R4");
        ins(64'h3004, NOP_ADD, 0, 0, "R4");
        ins(64'h3100, enc_i(6'h07, 5'd0, 16'h0004), 0, 0, "R4");
        ins(64'h3104, NOP_ADD, 0, 0, "R4");
        ins(64'h3200, enc_i(6'h07, 5'd0, 16'h0004), NEG, 0, "R4");
        ins(64'h3204, NOP_ADD, 0, 0, "R4");
        ins(64'h3300, enc_i(6'h06, 5'd0, 16'h0008), NEG, 0, "R4");
        ins(64'h3304, NOP_ADD, 0, 0, "R4");
        ins(64'h3400, enc_i(6'h07, 5'd0, 16'h0008), 64'h1_0000_0000, 0, "R4");
        ins(64'h3404, NOP_ADD, 0, 0, "R4");
        // R4: >=0 with zero taken (full 64-bit compare for equal)
        ins(64'h3500, enc_i(6'h01, 5'h01, 16'h0002), 0, 0, "R4");
        ins(64'h3504, NOP_ADD, 0, 0, "R4");
        ins(64'h3600, enc_i(6'h04, 5'd4, 16'h0002), 64'h1_0000_0005, 5, "R4");
        ins(64'h3604, NOP_ADD, 0, 0, "R4");
        // R6: likely equal not taken; slot holds a branch that must be ignored
        ins(64'h4000, enc_i(6'h14, 5'd4, 16'h0010), 1, 2, "R6");
        ins(64'h4004, enc_i(6'h04, 5'd4, 16'h0010), 7, 7, "R6");
        ins(64'h4008, NOP_ADD, 0, 0, "R6");
        idle("R6");
        // R6: likely not-equal taken behaves like a taken branch
        ins(64'h4100, enc_i(6'h15, 5'd4, 16'h0020), 1, 2, "R6");
        ins(64'h4104, NOP_ADD, 0, 0, "R6");
        // R6: likely >=0 with -5 not taken
        ins(64'h4200, enc_i(6'h01, 5'h03, 16'h0020), -64'sd5, 0, "R6");
        ins(64'h4204, NOP_ADD, 0, 0, "R6");
        idle("R6");
        // R3: region jump near the top of a region
        ins(64'hFFFF_0000_1234_5678, enc_j(6'h02, 26'h3FF_FFFF), 0, 0, "R3");
        ins(64'hFFFF_0000_1234_567C, NOP_ADD, 0, 0, "R3");
        idle("R3");
        // R7: linking jump
        ins(64'h0000_0000_2000_0010, enc_j(6'h03, 26'h000_0040), 0, 0, "R7");
        ins(64'h0000_0000_2000_0014, NOP_ADD, 0, 0, "R7");
        // R7: linking >=0 not taken still links, redirects to pc+8
        ins(64'h5000, enc_i(6'h01, 5'h11, 16'h0040), M1, 0, "R7");
        ins(64'h5004, NOP_ADD, 0, 0, "R7");
        // R7: linking likely not taken links and kills
        ins(64'h5100, enc_i(6'h01, 5'h13, 16'h0040), M1, 0, "R7");
        ins(64'h5104, NOP_ADD, 0, 0, "R7");
        idle("R7");
        // R8: linking jump in a delay slot faults, no link
        ins(64'h6000, enc_i(6'h04, 5'd4, 16'h0008), 3, 3, "R8");
        ins(64'h6004, enc_j(6'h03, 26'h000_1000), 0, 0, "R8");
        idle("R8");
        ins(64'h6100, enc_j(6'h02, 26'h000_0100), 0, 0, "R8");
        ins(64'h6104, enc_i(6'h05, 5'd4, 16'h0008), 1, 2, "R8");
        ins(64'h6108, NOP_ADD, 0, 0, "R8");
        // R9: idle cycles between branch and slot
        ins(64'h7000, enc_i(6'h04, 5'd4, 16'h0100), 9, 9, "R9");
        idle("R9"); idle("R9"); idle("R9");
        ins(64'h7004, NOP_ADD, 0, 0, "R9");
        idle("R9");
        // R1: reset between a branch and its slot clears the pending slot
        ins(64'h8000, enc_i(6'h04, 5'd4, 16'h0100), 9, 9, "R1");
        rst("R1");
        ins(64'h8004, NOP_ADD, 0, 0, "R1");
        ins(64'h8008, enc_i(6'h05, 5'd4, 16'h0004), 1, 1, "R1");
        ins(64'h800C, NOP_ADD, 0, 0, "R5");
        idle("R5");
        idle("R5");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule